// File: doc/BRIEF.md
# Fully Associative Translation Buffer Lookup

This block is a unified, fully associative translation buffer. It holds a parameterised number of entries, 64 by default. Each entry maps one virtual page to one physical page, and each entry picks one of four page sizes. A lookup request compares a virtual address against every entry in parallel. Entries that are invalid are ignored. Entries that belong to another address space are also ignored, unless the entry is marked shared or the address-space check is switched off.

The single entry that matches is then checked against the privilege mode and the access direction. The block reports either a translated physical address with a permitted-access mask, or one fault code. The fault codes cover a miss, a protection violation, a first write to a clean page, and more than one matching entry.

Entries are loaded through a write port. The write port carries the target index and every field of the entry. The lookup logic is combinational, and its result is captured in a register one clock after the request strobe.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so `rsp_valid_o` is low and any lookup reports a read or write miss.
- R2: A write through the entry port replaces the entry at `wr_idx_i` from the next clock on. A lookup requested in the same cycle as a write sees the old contents. Writing `wr_valid_i`=0 removes an entry from matching.
- R3: Size code 0/1/2/3 selects 1/4/64/1024 KiB pages. The region of an entry starts at `{vpn,10'b0}` with its page-offset bits cleared, and it covers exactly one page from that start.
- R4: A non-shared entry matches only when `asid_en_i`=0 or its ASID equals `cur_asid_i`. A shared entry ignores the ASID.
- R5: With no matching entry the fault code is 1 for a read and 2 for a write.
- R6: In user mode (`priv_i`=0), an entry whose protection bit 1 is clear gives fault 3 for a read and fault 4 for a write.
- R7: Otherwise, a write to an entry whose protection bit 0 is clear gives fault 4.
- R8: Otherwise, a write to an entry whose dirty bit is clear gives fault 5.
- R9: On success (fault 0), `rsp_perm_o[0]` (read) is always set. `rsp_perm_o[1]` (write) is set only when protection bit 0 and the dirty bit are both set.
- R10: On success, `rsp_pa_o` is `{ppn,10'b0}` with the page-offset bits cleared, ORed with the page-offset bits of the virtual address.
- R11: When more than one entry matches, the fault code is 6, and this code overrides every other result.
- R12: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_i` high. On any fault, `rsp_pa_o` and `rsp_perm_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W (6) | Entry index to write |
| wr_valid_i | input | 1 | Valid bit of written entry |
| wr_asid_i | input | ASID_W (8) | Address-space tag of written entry |
| wr_vpn_i | input | VA_W-10 (22) | Virtual page number |
| wr_ppn_i | input | PA_W-10 (22) | Physical page number |
| wr_size_i | input | 2 | Page size code |
| wr_shared_i | input | 1 | Shared entry, skips the ASID test |
| wr_prot_i | input | 2 | Protection key: bit 1 user access, bit 0 writable |
| wr_dirty_i | input | 1 | Dirty bit |
| req_i | input | 1 | Lookup request strobe |
| req_va_i | input | VA_W (32) | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| priv_i | input | 1 | 1 = privileged mode, 0 = user |
| cur_asid_i | input | ASID_W (8) | Current address-space tag |
| asid_en_i | input | 1 | Enables the ASID test |
| rsp_valid_o | output | 1 | Result valid |
| rsp_fault_o | output | 3 | Fault code, 0 = success |
| rsp_pa_o | output | PA_W (32) | Translated physical address |
| rsp_perm_o | output | 2 | Permitted access: bit 0 read, bit 1 write |

## Verification
The bench builds the block with its default parameters: 64 entries, 32-bit virtual and physical addresses and an 8-bit ASID. With these values the last index, 63, can be written and looked up. The full 1 MiB page also fits inside the address, so the bench tests its first byte past the end, and a 64 KiB entry whose page number has low bits set shows the offset clearing on both the virtual side and the physical side. The bench places one shared entry and one non-shared entry in different ASIDs to test the filter in both directions. It places an overlapping entry to test the multiple-hit code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PG_SHIFT = 10;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_MISS_RD  = 3'd1,
    FLT_MISS_WR  = 3'd2,
    FLT_PROT_RD  = 3'd3,
    FLT_PROT_WR  = 3'd4,
    FLT_FIRST_WR = 3'd5,
    FLT_MULTI    = 3'd6
  } fault_e;

  // offset width for a size code: 1K, 4K, 64K, 1M
  function automatic int unsigned off_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    off_bits = 10;
      2'd1:    off_bits = 12;
      2'd2:    off_bits = 16;
      default: off_bits = 20;
    endcase
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned N      = 64,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned VPN_W  = 22,
  parameter int unsigned PPN_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_shared_i,
  input  logic [1:0]        wr_prot_i,
  input  logic              wr_dirty_i,
  output logic [N-1:0]      valid_o,
  output logic [ASID_W-1:0] asid_o  [N],
  output logic [VPN_W-1:0]  vpn_o   [N],
  output logic [PPN_W-1:0]  ppn_o   [N],
  output logic [1:0]        size_o  [N],
  output logic [N-1:0]      shared_o,
  output logic [1:0]        prot_o  [N],
  output logic [N-1:0]      dirty_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i]  <= 1'b0;
        asid_o[i]   <= '0;
        vpn_o[i]    <= '0;
        ppn_o[i]    <= '0;
        size_o[i]   <= '0;
        shared_o[i] <= 1'b0;
        prot_o[i]   <= '0;
        dirty_o[i]  <= 1'b0;
      end else if (sel) begin
        valid_o[i]  <= wr_valid_i;
        asid_o[i]   <= wr_asid_i;
        vpn_o[i]    <= wr_vpn_i;
        ppn_o[i]    <= wr_ppn_i;
        size_o[i]   <= wr_size_i;
        shared_o[i] <= wr_shared_i;
        prot_o[i]   <= wr_prot_i;
        dirty_o[i]  <= wr_dirty_i;
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 64,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned VA_W   = 32,
  parameter int unsigned VPN_W  = 22
) (
  input  logic [N-1:0]      valid_i,
  input  logic [ASID_W-1:0] asid_i  [N],
  input  logic [VPN_W-1:0]  vpn_i   [N],
  input  logic [1:0]        size_i  [N],
  input  logic [N-1:0]      shared_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              asid_en_i,
  output logic [N-1:0]      hit_o
);
  import tlb_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VA_W-1:0] off_mask, base;
    logic            tag_ok;
    assign off_mask = (VA_W'(1) << off_bits(size_i[i])) - VA_W'(1);
    assign base     = {vpn_i[i], {PG_SHIFT{1'b0}}} & ~off_mask;
    assign tag_ok   = shared_i[i] || !asid_en_i || (asid_i[i] == cur_asid_i);
    assign hit_o[i] = valid_i[i] && tag_ok && ((va_i & ~off_mask) == base);
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve #(
  parameter int unsigned N     = 64,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PPN_W = 22
) (
  input  logic [N-1:0]     hit_i,
  input  logic [PPN_W-1:0] ppn_i  [N],
  input  logic [1:0]       size_i [N],
  input  logic [1:0]       prot_i [N],
  input  logic [N-1:0]     dirty_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             write_i,
  input  logic             priv_i,
  output logic [2:0]       fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       perm_o
);
  import tlb_pkg::*;

  logic [PPN_W-1:0] s_ppn;
  logic [1:0]       s_size, s_prot;
  logic             s_dirty, any_hit, multi;
  logic [PA_W-1:0]  pmask;
  fault_e           flt;

  // one-hot OR select; multi-hit result is overridden below
  always_comb begin
    s_ppn = '0; s_size = '0; s_prot = '0; s_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      s_ppn   |= ppn_i[i]  & {PPN_W{hit_i[i]}};
      s_size  |= size_i[i] & {2{hit_i[i]}};
      s_prot  |= prot_i[i] & {2{hit_i[i]}};
      s_dirty |= dirty_i[i] & hit_i[i];
    end
  end

  assign any_hit = |hit_i;
  assign multi   = |(hit_i & (hit_i - N'(1)));
  assign pmask   = (PA_W'(1) << off_bits(s_size)) - PA_W'(1);

  always_comb begin
    if (multi)                       flt = FLT_MULTI;
    else if (!any_hit)               flt = write_i ? FLT_MISS_WR : FLT_MISS_RD;
    else if (!priv_i && !s_prot[1])  flt = write_i ? FLT_PROT_WR : FLT_PROT_RD;
    else if (write_i && !s_prot[0])  flt = FLT_PROT_WR;
    else if (write_i && !s_dirty)    flt = FLT_FIRST_WR;
    else                             flt = FLT_NONE;
  end

  assign fault_o = flt;
  assign perm_o  = (flt == FLT_NONE) ? {s_prot[0] & s_dirty, 1'b1} : 2'b00;
  assign pa_o    = (flt == FLT_NONE)
                 ? (({s_ppn, {PG_SHIFT{1'b0}}} & ~pmask) | (PA_W'(va_i) & pmask))
                 : '0;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int unsigned N_ENT  = 64,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  localparam int unsigned IDX_W = $clog2(N_ENT),
  localparam int unsigned VPN_W = VA_W - tlb_pkg::PG_SHIFT,
  localparam int unsigned PPN_W = PA_W - tlb_pkg::PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_shared_i,
  input  logic [1:0]        wr_prot_i,
  input  logic              wr_dirty_i,
  input  logic              req_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic              req_write_i,
  input  logic              priv_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              asid_en_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_fault_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [1:0]        rsp_perm_o
);
  logic [N_ENT-1:0]  e_valid, e_shared, e_dirty, hit;
  logic [ASID_W-1:0] e_asid [N_ENT];
  logic [VPN_W-1:0]  e_vpn  [N_ENT];
  logic [PPN_W-1:0]  e_ppn  [N_ENT];
  logic [1:0]        e_size [N_ENT];
  logic [1:0]        e_prot [N_ENT];
  logic [2:0]        c_fault;
  logic [PA_W-1:0]   c_pa;
  logic [1:0]        c_perm;

  tlb_store #(.N(N_ENT), .IDX_W(IDX_W), .ASID_W(ASID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_asid_i, .wr_vpn_i,
    .wr_ppn_i, .wr_size_i, .wr_shared_i, .wr_prot_i, .wr_dirty_i,
    .valid_o(e_valid), .asid_o(e_asid), .vpn_o(e_vpn), .ppn_o(e_ppn),
    .size_o(e_size), .shared_o(e_shared), .prot_o(e_prot), .dirty_o(e_dirty)
  );

  tlb_match #(.N(N_ENT), .ASID_W(ASID_W), .VA_W(VA_W), .VPN_W(VPN_W)) u_match (
    .valid_i(e_valid), .asid_i(e_asid), .vpn_i(e_vpn), .size_i(e_size),
    .shared_i(e_shared), .va_i(req_va_i), .cur_asid_i, .asid_en_i, .hit_o(hit)
  );

  tlb_resolve #(.N(N_ENT), .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W)) u_resolve (
    .hit_i(hit), .ppn_i(e_ppn), .size_i(e_size), .prot_i(e_prot), .dirty_i(e_dirty),
    .va_i(req_va_i), .write_i(req_write_i), .priv_i,
    .fault_o(c_fault), .pa_o(c_pa), .perm_o(c_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= '0;
      rsp_pa_o    <= '0;
      rsp_perm_o  <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_fault_o <= c_fault;
        rsp_pa_o    <= c_pa;
        rsp_perm_o  <= c_perm;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            req_write_i,
  input logic            priv_i,
  input logic            rsp_valid_o,
  input logic [2:0]      rsp_fault_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [1:0]      rsp_perm_o
);
  p_rsp_after_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_rsp_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_fault_zero_out_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> (rsp_pa_o == '0 && rsp_perm_o == 2'b00));
  p_read_perm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 3'd0) |-> rsp_perm_o[0]);
  p_write_ok_perm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_write_i |=> (rsp_fault_o != 3'd0 || rsp_perm_o[1]));
  p_miss_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (rsp_fault_o != (req_write_i_q ? 3'd1 : 3'd2)));
  p_prot_rd_user_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && priv_i |=> rsp_fault_o != 3'd3);

  logic req_write_i_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) req_write_i_q <= 1'b0;
    else         req_write_i_q <= req_write_i;
endmodule

bind tlb_lookup tlb_lookup_chk #(.PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
  .priv_i(priv_i), .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o),
  .rsp_pa_o(rsp_pa_o), .rsp_perm_o(rsp_perm_o)
);

// File: tb/tlb_lookup_bench.sv
`timescale 1ns/1ps
module tlb_lookup_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 0, wr_valid_i = 0, wr_shared_i = 0, wr_dirty_i = 0;
  logic [5:0]  wr_idx_i = '0;
  logic [7:0]  wr_asid_i = '0, cur_asid_i = 8'd5;
  logic [21:0] wr_vpn_i = '0, wr_ppn_i = '0;
  logic [1:0]  wr_size_i = '0, wr_prot_i = '0;
  logic        req_i = 0, req_write_i = 0, priv_i = 0, asid_en_i = 1;
  logic [31:0] req_va_i = '0;
  logic        rsp_valid_o;
  logic [2:0]  rsp_fault_o;
  logic [31:0] rsp_pa_o;
  logic [1:0]  rsp_perm_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tlb_lookup u_tlb_lookup (.*);

  typedef struct packed {
    logic [7:0]  rq;
    logic [31:0] va;
    logic        wr;
    logic        pv;
    logic [7:0]  asid;
    logic        aen;
    logic [2:0]  flt;
    logic [31:0] pa;
    logic [1:0]  perm;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{8'd10, 32'h0001_0455, 1'b0, 1'b0, 8'd5, 1'b1, 3'd0, 32'h0004_0055, 2'b11},
    '{8'd3,  32'h0001_0800, 1'b0, 1'b0, 8'd5, 1'b1, 3'd1, 32'h0,         2'b00},
    '{8'd3,  32'h0001_07FF, 1'b1, 1'b0, 8'd5, 1'b1, 3'd0, 32'h0004_03FF, 2'b11},
    '{8'd7,  32'h0002_0ABC, 1'b1, 1'b0, 8'd5, 1'b1, 3'd4, 32'h0,         2'b00},
    '{8'd9,  32'h0002_0ABC, 1'b0, 1'b0, 8'd5, 1'b1, 3'd0, 32'h0008_0ABC, 2'b01},
    '{8'd6,  32'h0030_1234, 1'b0, 1'b0, 8'd5, 1'b1, 3'd3, 32'h0,         2'b00},
    '{8'd6,  32'h0030_1234, 1'b1, 1'b0, 8'd5, 1'b1, 3'd4, 32'h0,         2'b00},
    '{8'd10, 32'h0030_ABCD, 1'b0, 1'b1, 8'd5, 1'b1, 3'd0, 32'h0048_ABCD, 2'b11},
    '{8'd8,  32'h010F_FFFF, 1'b1, 1'b1, 8'd5, 1'b1, 3'd5, 32'h0,         2'b00},
    '{8'd9,  32'h010F_FFFF, 1'b0, 1'b0, 8'd5, 1'b1, 3'd0, 32'h020F_FFFF, 2'b01},
    '{8'd4,  32'h0005_0010, 1'b0, 1'b0, 8'd5, 1'b1, 3'd1, 32'h0,         2'b00},
    '{8'd4,  32'h0005_0010, 1'b1, 1'b0, 8'd5, 1'b0, 3'd0, 32'h000C_0010, 2'b11},
    '{8'd4,  32'h0005_0010, 1'b1, 1'b0, 8'd7, 1'b1, 3'd0, 32'h000C_0010, 2'b11},
    '{8'd5,  32'h0700_0000, 1'b1, 1'b1, 8'd5, 1'b1, 3'd2, 32'h0,         2'b00},
    '{8'd3,  32'h0110_0000, 1'b0, 1'b1, 8'd5, 1'b1, 3'd1, 32'h0,         2'b00}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] idx, input logic v, input logic [7:0] asid,
                     input logic [21:0] vpn, input logic [21:0] ppn, input logic [1:0] sz,
                     input logic sh, input logic [1:0] pr, input logic d);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = idx; wr_valid_i = v; wr_asid_i = asid; wr_vpn_i = vpn;
    wr_ppn_i = ppn; wr_size_i = sz; wr_shared_i = sh; wr_prot_i = pr; wr_dirty_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  // drive at a falling edge, result registered at the rising edge, read at next falling edge
  task automatic look(input logic [31:0] va, input logic wr, input logic pv);
    @(negedge clk_i);
    req_i = 1; req_va_i = va; req_write_i = wr; priv_i = pv;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic expect_rsp(string req, logic [2:0] f, logic [31:0] pa, logic [1:0] pm);
    chk({req, " valid"}, 64'(rsp_valid_o), 64'd1);
    chk({req, " fault"}, 64'(rsp_fault_o), 64'(f));
    chk({req, " pa"},    64'(rsp_pa_o),    64'(pa));
    chk({req, " perm"},  64'(rsp_perm_o),  64'(pm));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state and empty buffer
    chk("R1 idle valid", 64'(rsp_valid_o), 64'd0);
    look(32'h0001_0455, 1'b0, 1'b0);
    expect_rsp("R1 empty read", 3'd1, 32'h0, 2'b00);

    put(6'd0,  1, 8'd5, 22'h41,   22'h100,  2'd0, 0, 2'd3, 1);
    put(6'd1,  1, 8'd9, 22'h80,   22'h200,  2'd1, 1, 2'd2, 1);
    put(6'd2,  1, 8'd5, 22'hC3F,  22'h1234, 2'd2, 0, 2'd1, 1);
    put(6'd63, 1, 8'd1, 22'h4000, 22'h8000, 2'd3, 1, 2'd3, 0);
    put(6'd10, 1, 8'd7, 22'h140,  22'h300,  2'd1, 0, 2'd3, 1);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 15; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      cur_asid_i = VECS[i].asid; asid_en_i = VECS[i].aen;
      look(VECS[i].va, VECS[i].wr, VECS[i].pv);
      expect_rsp(tag, VECS[i].flt, VECS[i].pa, VECS[i].perm);
    end
    cur_asid_i = 8'd5; asid_en_i = 1;

    // R12: valid drops the cycle after an idle request slot
    @(negedge clk_i);
    chk("R12 valid low after idle", 64'(rsp_valid_o), 64'd0);

    // R2: write and lookup in the same cycle; lookup sees old content
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 6'd20; wr_valid_i = 1; wr_asid_i = 8'd0; wr_vpn_i = 22'h1000;
    wr_ppn_i = 22'h10; wr_size_i = 2'd1; wr_shared_i = 1; wr_prot_i = 2'd3; wr_dirty_i = 1;
    req_i = 1; req_va_i = 32'h0040_0123; req_write_i = 0; priv_i = 0;
    @(negedge clk_i);
    wr_en_i = 0; req_i = 0;
    expect_rsp("R2 same-cycle write", 3'd1, 32'h0, 2'b00);
    look(32'h0040_0123, 1'b0, 1'b0);
    expect_rsp("R2 after write", 3'd0, 32'h0000_4123, 2'b01 | 2'b10);

    // R11: overlapping entry with no user access; multi-hit wins over protection
    put(6'd30, 1, 8'd0, 22'h41, 22'h5, 2'd0, 1, 2'd0, 0);
    look(32'h0001_0455, 1'b0, 1'b0);
    expect_rsp("R11 multi hit", 3'd6, 32'h0, 2'b00);
    // R2: clearing the valid bit removes the entry from matching
    put(6'd30, 0, 8'd0, 22'h41, 22'h5, 2'd0, 1, 2'd0, 0);
    look(32'h0001_0455, 1'b0, 1'b0);
    expect_rsp("R2 invalidated", 3'd0, 32'h0004_0055, 2'b11);

    // R1: reset clears the loaded entries
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    chk("R1 valid after reset", 64'(rsp_valid_o), 64'd0);
    look(32'h0001_0455, 1'b1, 1'b1);
    expect_rsp("R1 miss after reset", 3'd2, 32'h0, 2'b00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule